// File: doc/BRIEF.md
# Output-Divider Double-Reset Sequencer

This block produces a two-pulse reset for the output clock divider of a serial transmitter. It is used whenever the PLL that feeds the transmitter reports lock. The block runs on a free-running clock that keeps toggling while the PLL is unlocked or held in reset. It never uses a clock derived from the transceiver. The lock-detect input is asynchronous, so it passes through a multi-flop synchronizer before its rising edge is detected.

On a qualifying start the block does four things in order:
- It waits a settling interval.
- It drives the divider reset high for a fixed pulse length.
- It drops the reset for a fixed gap.
- It drives a second pulse of the same length.

After the second pulse it raises a done flag and holds it. The sequence runs only when the divider setting is divide-by-2 or divide-by-4. The setting is captured when the sequence starts. A re-arm input lets surrounding logic restart the sequence while lock is held, for example after a power-down change or a transmitter reset. A loss of lock aborts any sequence in progress.

Top module: `txdiv_dbl_rst`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `div_rst_o` and `done_o` are low.
- R2: A low-to-high change of `lock_i` is seen after two synchronizer flops and starts a sequence. The state register then enters its settling phase on the third clock edge after the input change. `div_rst_o` first goes high `SETTLE_CYC` cycles after that.
- R3: A started sequence drives `div_rst_o` high for exactly `PULSE_CYC` cycles, then low for exactly `GAP_CYC` cycles, then high for exactly `PULSE_CYC` cycles. No other high cycles occur.
- R4: `div_sel_i` uses the codes 0 = divide-by-1, 1 = divide-by-2, 2 = divide-by-4 and 3 = divide-by-8. A start seen with code 0 or 3 produces no pulse on `div_rst_o`.
- R5: `done_o` rises in the cycle after the second pulse ends and stays high until the next start event. Any start event clears it, including one with a non-qualifying code.
- R6: A `rearm_i` pulse sampled while synchronized lock is high is a start event. If a sequence is already running, it restarts from the settling phase and `div_rst_o` is low on the next cycle.
- R7: A `rearm_i` pulse sampled while synchronized lock is low has no effect: `div_rst_o` and `done_o` keep their values.
- R8: When synchronized lock falls during a sequence, the block returns to idle on the next edge and `div_rst_o` goes low. With synchronizer latency, this is at most three edges after `lock_i` falls. `done_o` is not raised.
- R9: `div_sel_i` is latched at the start event. Changing it during a sequence does not alter the pulses.
- R10: When `rearm_i` arrives in the same cycle that synchronized lock is low, the abort takes priority and no new sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | PLL lock detect, asynchronous |
| div_sel_i | input | 2 | Output divider setting code |
| rearm_i | input | 1 | Restart request, synchronous to clk_i |
| div_rst_o | output | 1 | Divider reset, two pulses per sequence |
| done_o | output | 1 | Sequence complete, held until next start |

## Verification
Two functions can land on the same clock edge: a re-arm request and the abort caused by synchronized lock falling.

The bench provokes the collision in two steps. It first lowers `lock_i` during the second pulse. Two cycles later it drives `rearm_i` for one cycle, so the request meets the first edge at which synchronized lock is low. The bench then requires `div_rst_o` to stay low and `done_o` to stay clear for a whole sequence length, because abort wins.

A second collision is a re-arm arriving mid-pulse while lock is held. For that case the bench checks, cycle by cycle, that the sequence restarts from settling rather than continuing.

// File: rtl/txdr_pkg.sv
`timescale 1ns/1ps
package txdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_PULSE1 = 3'd2,
    ST_GAP    = 3'd3,
    ST_PULSE2 = 3'd4
  } seq_state_t;

  localparam logic [1:0] DIV_BY1 = 2'd0;
  localparam logic [1:0] DIV_BY2 = 2'd1;
  localparam logic [1:0] DIV_BY4 = 2'd2;
  localparam logic [1:0] DIV_BY8 = 2'd3;

  function automatic logic div_needs_rst(input logic [1:0] code);
    return (code == DIV_BY2) || (code == DIV_BY4);
  endfunction
endpackage

// File: rtl/txdr_sync.sv
`timescale 1ns/1ps
module txdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;

  // R2: a rising synchronized level had to be present one stage earlier
  a_r2_sync_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> $past(sh_q[0]));
endmodule

// File: rtl/txdr_timer.sv
`timescale 1ns/1ps
module txdr_timer #(
  parameter int CW      = 10,
  parameter int MAX_VAL = 1023
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign zero_o = (cnt_q == '0);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (32'(cnt_q) <= MAX_VAL));
  a_r3_cnt_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/txdr_ctrl.sv
`timescale 1ns/1ps
module txdr_ctrl
  import txdr_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int PULSE_CYC  = 256,
  parameter int GAP_CYC    = 256,
  parameter int CW         = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_s_i,
  input  logic          lock_rise_i,
  input  logic          rearm_i,
  input  logic [1:0]    div_sel_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          div_rst_o,
  output logic          done_o
);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GAP_LD    = CW'(GAP_CYC - 1);

  seq_state_t state_q, state_d;
  logic [1:0] div_q;
  logic       done_q, done_d;
  logic       start_evt;

  assign start_evt = lock_s_i & (lock_rise_i | rearm_i);

  always_comb begin
    state_d    = state_q;
    done_d     = done_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (!lock_s_i) begin
      state_d = ST_IDLE;                // abort beats everything
    end else if (start_evt) begin
      done_d = 1'b0;
      if (div_needs_rst(div_sel_i)) begin
        state_d    = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = SETTLE_LD;
      end else begin
        state_d = ST_IDLE;
      end
    end else if (tmr_zero_i) begin
      unique case (state_q)
        ST_SETTLE: begin
          state_d = ST_PULSE1; tmr_load_o = 1'b1; tmr_val_o = PULSE_LD;
        end
        ST_PULSE1: begin
          state_d = ST_GAP;    tmr_load_o = 1'b1; tmr_val_o = GAP_LD;
        end
        ST_GAP: begin
          state_d = ST_PULSE2; tmr_load_o = 1'b1; tmr_val_o = PULSE_LD;
        end
        ST_PULSE2: begin
          state_d = ST_IDLE;   done_d = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      div_q   <= DIV_BY1;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (start_evt) div_q <= div_sel_i;
    end

  assign div_rst_o = (state_q == ST_PULSE1) || (state_q == ST_PULSE2);
  assign done_o    = done_q;

  a_r4_pulse_needs_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> div_needs_rst(div_q));
  a_r8_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_s_i && state_q != ST_IDLE) |=> (state_q == ST_IDLE && !div_rst_o && !done_o));
  a_r6_start_drops_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (!div_rst_o && !done_o));
  a_r5_done_not_pulsing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));
  a_r3_phase_not_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tmr_zero_i && lock_s_i && !start_evt) |=> (state_q == $past(state_q)));
  a_r9_div_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !start_evt) |=> $stable(div_q));
endmodule

// File: rtl/txdiv_dbl_rst.sv
`timescale 1ns/1ps
module txdiv_dbl_rst #(
  parameter int SETTLE_CYC  = 1024,
  parameter int PULSE_CYC   = 256,
  parameter int GAP_CYC     = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic [1:0] div_sel_i,
  input  logic       rearm_i,
  output logic       div_rst_o,
  output logic       done_o
);
  localparam int MAX_A   = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int MAX_LEN = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CW      = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  logic          lock_s, lock_rise;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  txdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (lock_i),
    .level_o (lock_s),
    .rise_o  (lock_rise)
  );

  txdr_timer #(.CW(CW), .MAX_VAL(MAX_LEN - 1)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  txdr_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .GAP_CYC    (GAP_CYC),
    .CW         (CW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_s_i    (lock_s),
    .lock_rise_i (lock_rise),
    .rearm_i     (rearm_i),
    .div_sel_i   (div_sel_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .div_rst_o   (div_rst_o),
    .done_o      (done_o)
  );

  // R1: outputs quiet right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!div_rst_o && !done_o));
endmodule

// File: tb/txdiv_dbl_rst_tb.sv
`timescale 1ns/1ps
module txdiv_dbl_rst_tb;
  localparam int S  = 12;
  localparam int P  = 5;
  localparam int G  = 4;
  localparam int LR = 3;  // edges from lock_i change to settle state
  localparam int LA = 1;  // edges from rearm_i to settle state
  localparam int SEQ_END = S + 2*P + G;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       rearm = 1'b0;
  logic       div_rst, done;

  int checks = 0;
  int fails  = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always #4ns clk = ~clk;

  txdiv_dbl_rst #(.SETTLE_CYC(S), .PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .div_sel_i(div_sel),
    .rearm_i(rearm), .div_rst_o(div_rst), .done_o(done)
  );

  function automatic bit exp_rst(int k, int l0, bit qual);
    int t = k - l0 - S;
    return qual && ((t >= 0 && t < P) || (t >= P + G && t < 2*P + G));
  endfunction

  task automatic chk(string req, bit act, bit exp, string what, int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s k=%0d actual=%0b expected=%0b", req, what, k, act, exp);
    end
  endtask

  // samples n cycles; caller drove the start stimulus at the current negedge
  task automatic window(string req, int l0, bit qual, int n, int chg_k, logic [1:0] chg_v);
    bit ed = prev_done;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      rearm = 1'b0;
      ed = (k < l0) ? prev_done : (qual && k >= l0 + SEQ_END);
      chk(req, div_rst, exp_rst(k, l0, qual), "div_rst", k);
      chk(req, done, ed, "done", k);
      if (k == chg_k) div_sel = chg_v;
    end
    prev_done = ed;
  endtask

  // lock drop: outputs low from edge 3 on, done unchanged
  task automatic drop_lock(string req, int n, bit rearm_at2);
    lock = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      rearm = (rearm_at2 && k == 2);
      if (k >= LR) begin
        chk(req, div_rst, 1'b0, "div_rst", k);
        chk(req, done, prev_done, "done", k);
      end
    end
    rearm = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", div_rst, 1'b0, "div_rst in reset", 0);
    chk("R1", done, 1'b0, "done in reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", div_rst, 1'b0, "div_rst after reset", 0);
    chk("R1", done, 1'b0, "done after reset", 0);

    // R2 R3 R4 R5: sweep every divider code over a full lock cycle
    for (int c = 0; c < 4; c++) begin
      div_sel = 2'(c);
      lock = 1'b1;
      window((c == 1 || c == 2) ? "R2_R3_R5" : "R4_R5", LR, (c == 1 || c == 2), SEQ_END + 8, 0, 2'd0);
      drop_lock("R5_R8", 6, 1'b0);
    end

    // R7: rearm with lock low ignored
    rearm = 1'b1;
    window("R7", 1000, 1'b0, SEQ_END + 6, 0, 2'd0);

    // R9: divider changed mid-run to a non-qualifying code
    div_sel = 2'd2;
    lock = 1'b1;
    window("R9", LR, 1'b1, SEQ_END + 6, 8, 2'd3);
    // R5/R6: rearm after completion with code 1 restarts and clears done
    div_sel = 2'd1;
    rearm = 1'b1;
    window("R5_R6", LA, 1'b1, SEQ_END + 6, 0, 2'd0);

    // R6: rearm inside first pulse restarts from settle
    rearm = 1'b1;
    window("R6", LA, 1'b1, LA + S + 2, 0, 2'd0);
    rearm = 1'b1;
    window("R6", LA, 1'b1, SEQ_END + 6, 0, 2'd0);
    // R4: rearm with code 0 clears done, no pulse
    div_sel = 2'd0;
    rearm = 1'b1;
    window("R4_R5", LA, 1'b0, SEQ_END + 4, 0, 2'd0);
    drop_lock("R8", 4, 1'b0);

    // R8: abort mid first pulse
    div_sel = 2'd2;
    lock = 1'b1;
    window("R8", LR, 1'b1, LR + S + 2, 0, 2'd0);
    drop_lock("R8", SEQ_END + 4, 1'b0);

    // R10: abort in second pulse with rearm colliding with the lock fall
    lock = 1'b1;
    window("R10", LR, 1'b1, LR + S + P + G + 1, 0, 2'd0);
    drop_lock("R10", SEQ_END + 4, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule